// File: doc/BRIEF.md
# Parallel display bus strobe timer

This block runs single transfers on an 8080-style parallel display bus. A requester hands it one operation at a time through a ready/valid port. The operation is a command write, a parameter (data) write or a read. The block then drives the chip-select, write-strobe, read-strobe and register-select (A0) pins. It also drives the data bus during writes and samples it during reads. Every strobe edge falls on a programmed tick offset from the start of the transfer.

Two display devices can share the bus. Each has its own timing set, made of an on/off word, a cycle word and a double-tick flag. A 2-bit select input chooses the addressed device. Four polarity inputs set the active level of each pin. The bus data lines appear as separate output, output-enable and input vectors, so the pad ring can build the tristate buffer. The word sampled by the most recent read stays on `rd_word` until the next read replaces it.

Top module: `lcdbus_strobe_timer`

## Requirements
- R1: After a synchronous active-low reset, every strobe pin is at its inactive level and A0 sits at the command level. The data enable is low, `req_ready` is high and `rd_word` is zero.
- R2: The on/off word holds six fields, starting at bit 0: CS on [3:0], CS off [9:4], write on [13:10], write off [19:14], read on [23:20] and read off [29:24]. A strobe is active during exactly the ticks t with on <= t < off. Tick 0 is the clock that follows the edge on which the request was accepted.
- R3: The cycle word holds the write cycle length in [5:0], the read cycle length in [11:6] and the read access tick in [27:22]. Bits [21:12] do not affect the strobes. A transfer lasts max(cycle length of its kind, CS off) ticks, and `req_ready` is low for that whole time. After the transfer, `req_ready` is high for one idle clock before the next acceptance.
- R4: When the double-tick flag of the selected device is set, every tick lasts two clocks instead of one.
- R5: The `req_op` encoding is 0 = command write, 1 = parameter write, 2 or 3 = read. For the whole transfer, A0 is at the command level for a command write and at the data level for a parameter write or a read.
- R6: A read asserts only the read strobe and never enables the data bus. The bus is sampled on the first clock of the access tick, and the sampled word is held on `rd_word`.
- R7: A write enables the data bus from the write-on tick until the transfer ends, and it drives the word that was accepted with the request.
- R8: A polarity input of 0 makes its strobe active-low. A polarity input of 1 makes it active-high. For A0, 0 puts the command level low and the data level high, and 1 swaps the two levels.
- R9: `cs_select` value 1 addresses device 0 with timing set 0, and value 2 addresses device 1 with timing set 1. Values 0 and 3 run the transfer with timing set 0 and assert no chip select.
- R10: A request held valid while the block is busy is not lost. It is accepted on the first edge after the current transfer ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_op | input | 2 | Operation: 0 command, 1 parameter, 2/3 read |
| req_data | input | DATA_W | Word to write |
| cs_select | input | 2 | Device address: 1 dev0, 2 dev1, else none |
| dev0_onoff | input | 30 | Device 0 on/off tick word |
| dev0_cycle | input | 28 | Device 0 cycle word |
| dev1_onoff | input | 30 | Device 1 on/off tick word |
| dev1_cycle | input | 28 | Device 1 cycle word |
| tick_x2 | input | 2 | Per-device double-tick flag |
| pol_a0 | input | 1 | A0 polarity |
| pol_re | input | 1 | Read strobe polarity |
| pol_we | input | 1 | Write strobe polarity |
| pol_cs | input | 1 | Chip-select polarity |
| bus_cs | output | 2 | Chip-select pins, one per device |
| bus_we | output | 1 | Write strobe pin |
| bus_re | output | 1 | Read strobe pin |
| bus_a0 | output | 1 | Register-select pin |
| bus_dout | output | DATA_W | Data driven to the bus |
| bus_doe | output | 1 | Data output enable |
| bus_din | input | DATA_W | Data sampled from the bus |
| rd_word | output | DATA_W | Word captured by the last read |

## Verification
The bench replays each transfer one clock at a time against a tick model and compares every pin on every clock. An off-by-one in an on or off comparison therefore shows up as a strobe that is one tick too long or too short. The transfer length is exercised both where the cycle length wins and where CS off wins. A design that ignored either term would release ready early, which would clip the chip select or the read. During reads the bench changes the bus value on every clock, so a sample taken on the wrong clock returns the wrong word. The remaining cases are the doubled tick, the swapped polarities, a select of none, and a request held across a busy transfer. A design that dropped the held request, or accepted it with no idle clock, would misplace the second transfer.

// File: rtl/lcdbus_pkg.sv
// Shared layout constants and the decoded timing-set type for the
// parallel display strobe timer. The field positions are fixed by the
// timing words that software writes, so they live here and nowhere else.
package lcdbus_pkg;

    localparam int ON_W     = 4;                  // width of an "on" tick field
    localparam int OFF_W    = 6;                  // width of an "off"/cycle field
    localparam int SLOT_W   = ON_W + OFF_W;       // one strobe's on/off pair
    localparam int ONOFF_W  = 3 * SLOT_W;         // CS, WE, RE pairs
    localparam int ACC_LSB  = 22;                 // access tick position in cycle word
    localparam int CYC_W    = ACC_LSB + OFF_W;    // cycle word width
    localparam int NUM_DEV  = 2;                  // devices sharing the bus

    typedef enum logic [1:0] {
        OP_CMD   = 2'd0,
        OP_PARAM = 2'd1,
        OP_READ  = 2'd2,
        OP_READ2 = 2'd3
    } op_e;

    typedef struct packed {
        logic [ON_W-1:0]  cs_on;
        logic [OFF_W-1:0] cs_off;
        logic [ON_W-1:0]  we_on;
        logic [OFF_W-1:0] we_off;
        logic [ON_W-1:0]  re_on;
        logic [OFF_W-1:0] re_off;
        logic [OFF_W-1:0] we_cyc;
        logic [OFF_W-1:0] re_cyc;
        logic [OFF_W-1:0] acc;
    } tim_t;

endpackage

// File: rtl/lcdbus_timing_decode.sv
// Splits one device's on/off word and cycle word into named tick fields.
// Assumes the field layout in lcdbus_pkg; bits [ACC_LSB-1:2*OFF_W] of the
// cycle word carry nothing the strobes use and are dropped here.
module lcdbus_timing_decode
    import lcdbus_pkg::*;
(
    input  logic [ONOFF_W-1:0] onoff,
    input  logic [CYC_W-1:0]   cyc,
    output tim_t               tim
);

    // Field extraction from the on/off word.
    always_comb begin
        tim.cs_on  = onoff[ON_W-1:0];
        tim.cs_off = onoff[SLOT_W-1:ON_W];
        tim.we_on  = onoff[SLOT_W+ON_W-1:SLOT_W];
        tim.we_off = onoff[2*SLOT_W-1:SLOT_W+ON_W];
        tim.re_on  = onoff[2*SLOT_W+ON_W-1:2*SLOT_W];
        tim.re_off = onoff[3*SLOT_W-1:2*SLOT_W+ON_W];
        tim.we_cyc = cyc[OFF_W-1:0];
        tim.re_cyc = cyc[2*OFF_W-1:OFF_W];
        tim.acc    = cyc[CYC_W-1:ACC_LSB];
    end

    wire unused_gap = ^cyc[ACC_LSB-1:2*OFF_W];

endmodule

// File: rtl/lcdbus_ticker.sv
// Transfer sequencer: counts ticks from 0 up to len-1, each tick lasting
// one or two clocks. Exposes both the registered and the next-state tick
// so strobe flops can be loaded in step with the counter.
// Assumes start is only raised while idle; len and the doubling flag are
// latched at start and held for the whole transfer.
module lcdbus_ticker
    import lcdbus_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             dbl,
    input  logic [OFF_W-1:0] len_in,
    output logic             busy,
    output logic [OFF_W-1:0] tick,
    output logic             first,
    output logic             busy_nx,
    output logic [OFF_W-1:0] tick_nx
);

    logic             busy_q, ph_q, ph_nx, dbl_q;
    logic [OFF_W-1:0] tick_q, len_q;

    // Next tick, phase and busy state.
    always_comb begin
        busy_nx = busy_q;
        tick_nx = tick_q;
        ph_nx   = ph_q;
        if (busy_q) begin
            if (ph_q == dbl_q) begin
                ph_nx = 1'b0;
                if (tick_q == len_q - OFF_W'(1)) begin
                    busy_nx = 1'b0;
                    tick_nx = '0;
                end else begin
                    tick_nx = tick_q + OFF_W'(1);
                end
            end else begin
                ph_nx = 1'b1;
            end
        end else if (start) begin
            busy_nx = 1'b1;
            tick_nx = '0;
            ph_nx   = 1'b0;
        end
    end

    // State registers; length and doubling latched at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            tick_q <= '0;
            ph_q   <= 1'b0;
            dbl_q  <= 1'b0;
            len_q  <= OFF_W'(1);
        end else begin
            busy_q <= busy_nx;
            tick_q <= tick_nx;
            ph_q   <= ph_nx;
            if (start && !busy_q) begin
                dbl_q <= dbl;
                len_q <= (len_in == '0) ? OFF_W'(1) : len_in;
            end
        end
    end

    assign busy  = busy_q;
    assign tick  = tick_q;
    assign first = ~ph_q;

    a_r3_starts_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) |-> (tick_q == '0 && !ph_q));
    a_r3_within_length: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (tick_q < len_q));
    a_r4_single_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !dbl_q) |-> !ph_q);

endmodule

// File: rtl/lcdbus_window.sv
// One strobe: a flop that is set while the upcoming tick lies in
// [t_on, t_off) and the enable is high. Inputs are next-state values so
// the flop output lines up with the ticker's registered tick.
module lcdbus_window #(
    parameter int ON_BITS  = 4,
    parameter int OFF_BITS = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en_nx,
    input  logic [OFF_BITS-1:0] tick_nx,
    input  logic [ON_BITS-1:0]  t_on,
    input  logic [OFF_BITS-1:0] t_off,
    output logic                act
);

    // Window compare registered into the strobe flop.
    always_ff @(posedge clk) begin
        if (!rst_n) act <= 1'b0;
        else        act <= en_nx && (tick_nx >= OFF_BITS'(t_on)) && (tick_nx < t_off);
    end

endmodule

// File: rtl/lcdbus_strobe_timer.sv
// Parallel display bus strobe timer (top). Accepts one command, parameter
// or read request at a time, latches the selected device's timing set and
// plays the chip-select, write, read and A0 strobes against the tick count.
// Assumes the programmed set obeys off > on for each strobe, CS off at
// least both write off and read off, cycle lengths at least their off
// ticks, and access tick above read on; the block does not repair them.
module lcdbus_strobe_timer
    import lcdbus_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [1:0]         req_op,
    input  logic [DATA_W-1:0]  req_data,
    input  logic [1:0]         cs_select,
    input  logic [ONOFF_W-1:0] dev0_onoff,
    input  logic [CYC_W-1:0]   dev0_cycle,
    input  logic [ONOFF_W-1:0] dev1_onoff,
    input  logic [CYC_W-1:0]   dev1_cycle,
    input  logic [NUM_DEV-1:0] tick_x2,
    input  logic               pol_a0,
    input  logic               pol_re,
    input  logic               pol_we,
    input  logic               pol_cs,
    output logic [NUM_DEV-1:0] bus_cs,
    output logic               bus_we,
    output logic               bus_re,
    output logic               bus_a0,
    output logic [DATA_W-1:0]  bus_dout,
    output logic               bus_doe,
    input  logic [DATA_W-1:0]  bus_din,
    output logic [DATA_W-1:0]  rd_word
);

    logic [ONOFF_W-1:0] onoff_arr [NUM_DEV];
    logic [CYC_W-1:0]   cyc_arr   [NUM_DEV];
    tim_t               tim_set   [NUM_DEV];
    logic [NUM_DEV-1:0] hit_sel;

    assign onoff_arr[0] = dev0_onoff;
    assign onoff_arr[1] = dev1_onoff;
    assign cyc_arr[0]   = dev0_cycle;
    assign cyc_arr[1]   = dev1_cycle;

    for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
        lcdbus_timing_decode u_dec (
            .onoff (onoff_arr[g]),
            .cyc   (cyc_arr[g]),
            .tim   (tim_set[g])
        );
        assign hit_sel[g] = (cs_select == 2'(g + 1));
    end

    logic set_idx;
    tim_t tim_sel;
    assign set_idx = (cs_select == 2'd2);
    assign tim_sel = tim_set[set_idx];

    // Transfer length: longer of the kind's cycle length and CS off.
    logic [OFF_W-1:0] cyc_sel, len_sel;
    always_comb begin
        cyc_sel = req_op[1] ? tim_sel.re_cyc : tim_sel.we_cyc;
        len_sel = (cyc_sel > tim_sel.cs_off) ? cyc_sel : tim_sel.cs_off;
    end

    logic             busy, busy_nx, first, accept;
    logic [OFF_W-1:0] tick, tick_nx;

    assign req_ready = ~busy;
    assign accept    = req_valid & ~busy;

    lcdbus_ticker u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (accept),
        .dbl     (tick_x2[set_idx]),
        .len_in  (len_sel),
        .busy    (busy),
        .tick    (tick),
        .first   (first),
        .busy_nx (busy_nx),
        .tick_nx (tick_nx)
    );

    // Transfer context: kind, A0 level, addressed device, data, timing.
    logic               rd_q, rd_nx, a0_q, a0_nx;
    logic [NUM_DEV-1:0] hit_q, hit_nx;
    logic [DATA_W-1:0]  data_q;
    tim_t               tim_q, tim_nx;

    always_comb begin
        rd_nx  = accept ? req_op[1]                 : rd_q;
        a0_nx  = accept ? (op_e'(req_op) != OP_CMD) : a0_q;
        hit_nx = accept ? hit_sel                   : hit_q;
        tim_nx = accept ? tim_sel                   : tim_q;
    end

    // Context registers loaded on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q   <= 1'b0;
            a0_q   <= 1'b0;
            hit_q  <= '0;
            data_q <= '0;
            tim_q  <= '0;
        end else begin
            rd_q  <= rd_nx;
            a0_q  <= a0_nx;
            hit_q <= hit_nx;
            tim_q <= tim_nx;
            if (accept) data_q <= req_data;
        end
    end

    logic               we_act, re_act;
    logic [NUM_DEV-1:0] cs_act;

    lcdbus_window #(.ON_BITS(ON_W), .OFF_BITS(OFF_W)) u_we (
        .clk (clk), .rst_n (rst_n),
        .en_nx (busy_nx & ~rd_nx), .tick_nx (tick_nx),
        .t_on (tim_nx.we_on), .t_off (tim_nx.we_off), .act (we_act)
    );

    lcdbus_window #(.ON_BITS(ON_W), .OFF_BITS(OFF_W)) u_re (
        .clk (clk), .rst_n (rst_n),
        .en_nx (busy_nx & rd_nx), .tick_nx (tick_nx),
        .t_on (tim_nx.re_on), .t_off (tim_nx.re_off), .act (re_act)
    );

    for (genvar g = 0; g < NUM_DEV; g++) begin : g_cs
        lcdbus_window #(.ON_BITS(ON_W), .OFF_BITS(OFF_W)) u_cs (
            .clk (clk), .rst_n (rst_n),
            .en_nx (busy_nx & hit_nx[g]), .tick_nx (tick_nx),
            .t_on (tim_nx.cs_on), .t_off (tim_nx.cs_off), .act (cs_act[g])
        );
    end

    // A0 level, data enable and read capture.
    logic              a0_act, doe_q;
    logic [DATA_W-1:0] rd_q_word;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a0_act    <= 1'b0;
            doe_q     <= 1'b0;
            rd_q_word <= '0;
        end else begin
            a0_act <= busy_nx & a0_nx;
            doe_q  <= busy_nx & ~rd_nx & (tick_nx >= OFF_W'(tim_nx.we_on));
            if (busy && rd_q && first && tick == tim_q.acc)
                rd_q_word <= bus_din;
        end
    end

    assign bus_we   = we_act ~^ pol_we;
    assign bus_re   = re_act ~^ pol_re;
    assign bus_cs   = cs_act ~^ {NUM_DEV{pol_cs}};
    assign bus_a0   = a0_act ^ pol_a0;
    assign bus_doe  = doe_q;
    assign bus_dout = data_q;
    assign rd_word  = rd_q_word;

    a_r6_no_drive_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_q) |-> !doe_q);
    a_r2_we_re_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(we_act && re_act));
    a_r9_cs_onehot0: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs_act));
    a_r7_drive_only_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        doe_q |-> (busy && !rd_q));
    a_r10_held_request_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);

endmodule

// File: tb/lcdbus_strobe_timer_tb.sv
`timescale 1ns/1ps
// Directed bench for the strobe timer: each task sets up one scenario,
// replays the transfer clock by clock against a tick model and counts.
module lcdbus_strobe_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'd0;
    logic [15:0] req_data = '0;
    logic [1:0]  cs_select = 2'd1;
    logic [29:0] cfg_oo0, cfg_oo1;
    logic [27:0] cfg_cy0, cfg_cy1;
    logic [1:0]  cfg_x2 = 2'b00;
    logic        p_a0 = 0, p_re = 0, p_we = 0, p_cs = 0;
    logic [1:0]  bus_cs;
    logic        bus_we, bus_re, bus_a0, bus_doe;
    logic [15:0] bus_dout, bus_din = '0, rd_word;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    lcdbus_strobe_timer #(.DATA_W(16)) dut_i (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_ready (req_ready),
        .req_op (req_op), .req_data (req_data), .cs_select (cs_select),
        .dev0_onoff (cfg_oo0), .dev0_cycle (cfg_cy0),
        .dev1_onoff (cfg_oo1), .dev1_cycle (cfg_cy1),
        .tick_x2 (cfg_x2),
        .pol_a0 (p_a0), .pol_re (p_re), .pol_we (p_we), .pol_cs (p_cs),
        .bus_cs (bus_cs), .bus_we (bus_we), .bus_re (bus_re), .bus_a0 (bus_a0),
        .bus_dout (bus_dout), .bus_doe (bus_doe), .bus_din (bus_din),
        .rd_word (rd_word)
    );

    function automatic logic [29:0] mk_oo(int cson, int csoff, int weon, int weoff, int reon, int reoff);
        return {6'(reoff), 4'(reon), 6'(weoff), 4'(weon), 6'(csoff), 4'(cson)};
    endfunction

    function automatic logic [27:0] mk_cy(int wecyc, int recyc, int acc);
        return {6'(acc), 10'h2A5, 6'(recyc), 6'(wecyc)};
    endfunction

    function automatic int fld(logic [31:0] w, int lsb, int width);
        return int'((w >> lsb) & ((32'd1 << width) - 1));
    endfunction

    function automatic logic pin(logic act, logic pol);
        return act ? pol : ~pol;
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        req_valid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Present a request at a falling edge; it is accepted on the next rising edge.
    task automatic issue(input logic [1:0] op, input logic [15:0] data, input logic [1:0] sel);
        @(negedge clk);
        req_op = op; req_data = data; cs_select = sel; req_valid = 1'b1;
        @(posedge clk);
    endtask

    // Compare every pin on each clock after the accepting edge against the tick model.
    task automatic check_trace(input string req, input logic [1:0] op, input logic [1:0] sel,
                               input logic [15:0] data, input int nint, input bit keep_valid);
        int si, g, cson, csoff, weon, weoff, reon, reoff, wecyc, recyc, acc, len;
        logic [29:0] oo;
        logic [27:0] cy;
        bit rd;
        si = (sel == 2'd2) ? 1 : 0;
        oo = si ? cfg_oo1 : cfg_oo0;
        cy = si ? cfg_cy1 : cfg_cy0;
        g  = cfg_x2[si] ? 2 : 1;
        cson = fld(32'(oo), 0, 4);   csoff = fld(32'(oo), 4, 6);
        weon = fld(32'(oo), 10, 4);  weoff = fld(32'(oo), 14, 6);
        reon = fld(32'(oo), 20, 4);  reoff = fld(32'(oo), 24, 6);
        wecyc = fld(32'(cy), 0, 6);  recyc = fld(32'(cy), 6, 6);
        acc  = fld(32'(cy), 22, 6);
        rd  = op[1];
        len = rd ? recyc : wecyc;
        if (csoff > len) len = csoff;
        if (len == 0) len = 1;
        for (int c = 0; c < nint; c++) begin
            int t;
            bit bz, we_e, re_e, a0_e, doe_e;
            logic [1:0] cs_e;
            logic [6:0] exp_v, act_v;
            @(negedge clk);
            if (c == 0 && !keep_valid) req_valid = 1'b0;
            t = c / g;
            bz = (t < len);
            we_e  = bz && !rd && t >= weon && t < weoff;
            re_e  = bz && rd && t >= reon && t < reoff;
            doe_e = bz && !rd && t >= weon;
            a0_e  = bz && (op != 2'd0);
            for (int i = 0; i < 2; i++)
                cs_e[i] = bz && (sel == 2'(i + 1)) && t >= cson && t < csoff;
            exp_v = {!bz, pin(cs_e[1], p_cs), pin(cs_e[0], p_cs), pin(we_e, p_we),
                     pin(re_e, p_re), a0_e ^ p_a0, doe_e};
            act_v = {req_ready, bus_cs, bus_we, bus_re, bus_a0, bus_doe};
            chk(req, $sformatf("pins clk %0d {rdy,cs,we,re,a0,oe}", c), 32'(act_v), 32'(exp_v));
            if (doe_e) chk(req, "write data (R7)", 32'(bus_dout), 32'(data));
            if (rd) bus_din = 16'hA500 + 16'(c);
        end
        if (rd) chk(req, "captured word", 32'(rd_word), 32'(16'hA500 + 16'(acc * g)));
    endtask

    // R1: idle state after reset.
    task automatic t_reset();
        do_reset();
        @(negedge clk);
        chk("R1", "ready", 32'(req_ready), 32'd1);
        chk("R1", "cs pins", 32'(bus_cs), 32'd3);
        chk("R1", "we/re pins", 32'({bus_we, bus_re}), 32'd3);
        chk("R1", "a0 command level", 32'(bus_a0), 32'd0);
        chk("R1", "data enable", 32'(bus_doe), 32'd0);
        chk("R1", "read word", 32'(rd_word), 32'd0);
    endtask

    // R2, R3, R5, R7: command write on device 0; CS off sets the length.
    task automatic t_cmd_write();
        issue(2'd0, 16'hC3A5, 2'd1);
        check_trace("R2", 2'd0, 2'd1, 16'hC3A5, 11, 1'b0);
    endtask

    // R9, R5, R3: parameter write on device 1 with its own set; cycle length wins.
    task automatic t_param_dev1();
        issue(2'd1, 16'h5A17, 2'd2);
        check_trace("R9", 2'd1, 2'd2, 16'h5A17, 12, 1'b0);
    endtask

    // R4: doubled tick on device 0.
    task automatic t_granularity();
        cfg_x2 = 2'b01;
        issue(2'd1, 16'h0F0F, 2'd1);
        check_trace("R4", 2'd1, 2'd1, 16'h0F0F, 20, 1'b0);
        issue(2'd2, 16'h0000, 2'd1);
        check_trace("R4", 2'd2, 2'd1, 16'h0000, 26, 1'b0);
        cfg_x2 = 2'b00;
    endtask

    // R6: reads on each device, op codes 2 and 3, sampling point checked by a moving bus.
    task automatic t_read();
        issue(2'd2, 16'hFFFF, 2'd1);
        check_trace("R6", 2'd2, 2'd1, 16'hFFFF, 14, 1'b0);
        issue(2'd3, 16'h1234, 2'd2);
        check_trace("R6", 2'd3, 2'd2, 16'h1234, 10, 1'b0);
        @(negedge clk);
        chk("R6", "read word held while idle", 32'(rd_word), 32'(16'hA500 + 16'd3));
    endtask

    // R8: every polarity swapped.
    task automatic t_polarity();
        p_a0 = 1; p_re = 1; p_we = 1; p_cs = 1;
        @(negedge clk);
        chk("R8", "idle pins inverted {cs,we,re,a0}", 32'({bus_cs, bus_we, bus_re, bus_a0}), 32'b00001);
        issue(2'd0, 16'h8001, 2'd1);
        check_trace("R8", 2'd0, 2'd1, 16'h8001, 11, 1'b0);
        issue(2'd2, 16'h0000, 2'd2);
        check_trace("R8", 2'd2, 2'd2, 16'h0000, 8, 1'b0);
        p_a0 = 0; p_re = 0; p_we = 0; p_cs = 0;
    endtask

    // R9: select values 0 and 3 run set 0 with no chip select.
    task automatic t_no_select();
        issue(2'd1, 16'h7777, 2'd0);
        check_trace("R9", 2'd1, 2'd0, 16'h7777, 11, 1'b0);
        issue(2'd0, 16'h6666, 2'd3);
        check_trace("R9", 2'd0, 2'd3, 16'h6666, 11, 1'b0);
    endtask

    // R10: a request held across a busy transfer starts after one idle clock.
    task automatic t_holdoff();
        issue(2'd0, 16'h1111, 2'd1);
        #1;
        req_op = 2'd1; req_data = 16'h2222;
        check_trace("R10", 2'd0, 2'd1, 16'h1111, 9, 1'b1);
        @(negedge clk);
        chk("R10", "idle clock ready", 32'(req_ready), 32'd1);
        chk("R10", "idle clock we pin", 32'(bus_we), 32'd1);
        @(posedge clk);
        check_trace("R10", 2'd1, 2'd1, 16'h2222, 11, 1'b0);
    endtask

    initial begin
        // Set 0: CS 1..9, WE 2..5, RE 3..8, write cycle 7, read cycle 12, access 6.
        cfg_oo0 = mk_oo(1, 9, 2, 5, 3, 8);
        cfg_cy0 = mk_cy(7, 12, 6);
        // Set 1: CS 0..6, WE 1..4, RE 1..5, write cycle 10, read cycle 6, access 3.
        cfg_oo1 = mk_oo(0, 6, 1, 4, 1, 5);
        cfg_cy1 = mk_cy(10, 6, 3);
        t_reset();
        t_cmd_write();
        t_param_dev1();
        t_granularity();
        t_read();
        t_polarity();
        t_no_select();
        t_holdoff();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule